// File: doc/BRIEF.md
# Supply and Strobe Write-Inhibit Guard

This block sits in front of a non-volatile memory write controller. It passes a write request on only when it is safe to do so. Three protections are combined in one qualification path.

- **Supply lockout.** A digital supply-good bit comes from an external comparator. The analog threshold sensing is done outside the block.
- **Power-on hold-off.** After the supply becomes good, a timer must run to completion before any write is allowed.
- **Strobe glitch filter.** The active-low write-enable and chip-enable strobes must each stay low for a minimum run of clock cycles.

On top of these, the static pin conditions block every write: output enable driven low, chip enable high, or write enable high.

The block has two outputs. The first is a qualified write strobe, which the controller uses to start a write. The second is an inhibit flag, which reports that one of the lockout or static conditions is present. The hold-off length and the filter length are parameters counted in clock cycles. For example, at 200 MHz a 5 ms hold-off is 1,000,000 cycles and a 15 ns filter is 3 cycles.

Top module: `wg_write_guard`

## Requirements
- R1: While the sampled supply-good input is 0, the write strobe output is 0 and the inhibit flag is 1, from the first clock edge that samples the 0.
- R2: The supply counts as ready only after HOLD_CYCLES consecutive clock edges sample supply-good as 1. Before that edge the write strobe is 0 and the inhibit flag is 1.
- R3: A single edge that samples supply-good as 0 restarts the hold-off, so the full HOLD_CYCLES consecutive good samples are needed again.
- R4: An edge that samples output enable low (0) blocks the write strobe and raises the inhibit flag.
- R5: An edge that samples chip enable high (1) blocks the write strobe and raises the inhibit flag.
- R6: An edge that samples write enable high (1) blocks the write strobe and raises the inhibit flag.
- R7: A low pulse on write enable or chip enable that is shorter than GLITCH_CYCLES consecutive sampled edges never asserts the write strobe.
- R8: The write strobe is 1 from the edge at which all of the following hold: the supply is ready, output enable is sampled high, and both write enable and chip enable have each been sampled low on at least GLITCH_CYCLES consecutive edges. It stays 1 while these hold and falls at the first edge that samples either strobe high.
- R9: The inhibit flag is 1 exactly when the supply is not ready, or output enable is sampled low, or write enable or chip enable is sampled high. It stays 0 while both strobes are low and the filter run is still in progress.
- R10: During reset and right after it, the write strobe is 0 and the inhibit flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply above write threshold (1 = good) |
| we_n_i | input | 1 | Write enable strobe, active low |
| ce_n_i | input | 1 | Chip enable strobe, active low |
| oe_n_i | input | 1 | Output enable, active low; low inhibits writes |
| wr_qual_o | output | 1 | Qualified write strobe to the write controller |
| wr_inhibit_o | output | 1 | Some lockout or static inhibit condition holds |

## Verification
Both outputs are decoded from registers, so every result reflects the pins sampled at the most recent rising edge, with no further latency. The write strobe follows the GLITCH_CYCLES-th consecutive low sample of the strobes. Readiness follows the HOLD_CYCLES-th consecutive good supply sample. The bench drives pins on falling edges and updates a counting model of the requirements for the edge that follows. It queues the expected pair of outputs, and a monitor compares that pair one time unit after that rising edge, so each stimulus is checked exactly at the edge where its effect is due.

// File: rtl/wg_pkg.sv
package wg_pkg;

    // Index of each filtered strobe in the strobe vector
    typedef enum int unsigned {
        STB_WE = 0,
        STB_CE = 1
    } wg_strobe_e;

    localparam int unsigned WG_NUM_STROBES = 2;

    // Registered output pair of the guard
    typedef struct packed {
        logic wr;
        logic inh;
    } wg_out_t;

endpackage

// File: rtl/wg_supply_timer.sv
module wg_supply_timer #(
    parameter int unsigned HOLD_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    output logic ready_o
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!supply_ok_i) begin
            s_d.cnt   = '0;
            s_d.ready = 1'b0;
        end else begin
            if (s_q.cnt != HOLD_V) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
            s_d.ready = (s_d.cnt == HOLD_V);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready_o = s_q.ready;

    // R1: a bad supply sample drops readiness at that edge
    p_bad_supply_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> !ready_o);

    // R2: readiness only appears after the counter reached its last step
    p_ready_after_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(s_q.cnt) == HOLD_V - 1'b1) && $past(supply_ok_i));

    // R3: a restart leaves the counter at zero
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> (s_q.cnt == '0));

endmodule

// File: rtl/wg_strobe_filter.sv
module wg_strobe_filter #(
    parameter int unsigned GLITCH_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n_i,
    output logic low_o,
    output logic idle_o
);
    localparam int unsigned CW = $clog2(GLITCH_CYCLES + 1);
    localparam logic [CW-1:0] LEN_V = CW'(GLITCH_CYCLES);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          low;
    } flt_t;

    flt_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (strobe_n_i) begin
            s_d.run = '0;
            s_d.low = 1'b0;
        end else begin
            if (s_q.run != LEN_V) begin
                s_d.run = s_q.run + 1'b1;
            end
            s_d.low = (s_d.run == LEN_V);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign low_o  = s_q.low;
    assign idle_o = (s_q.run == '0);

    // R7: a qualified low needs the full run of low samples
    p_low_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_o) |-> !$past(strobe_n_i) && ($past(s_q.run) == LEN_V - 1'b1));

    // R8: a high sample releases the strobe at once
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_n_i |=> (!low_o && idle_o));

endmodule

// File: rtl/wg_write_guard.sv
module wg_write_guard
    import wg_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES   = 1000000,
    parameter int unsigned GLITCH_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic we_n_i,
    input  logic ce_n_i,
    input  logic oe_n_i,
    output logic wr_qual_o,
    output logic wr_inhibit_o
);
    logic                      ready;
    logic [WG_NUM_STROBES-1:0] stb_n;
    logic [WG_NUM_STROBES-1:0] stb_low;
    logic [WG_NUM_STROBES-1:0] stb_idle;

    assign stb_n[STB_WE] = we_n_i;
    assign stb_n[STB_CE] = ce_n_i;

    wg_supply_timer #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (supply_ok_i),
        .ready_o     (ready)
    );

    for (genvar g = 0; g < WG_NUM_STROBES; g++) begin : g_flt
        wg_strobe_filter #(
            .GLITCH_CYCLES (GLITCH_CYCLES)
        ) u_flt (
            .clk        (clk),
            .rst_n      (rst_n),
            .strobe_n_i (stb_n[g]),
            .low_o      (stb_low[g]),
            .idle_o     (stb_idle[g])
        );
    end

    // Sampled output enable, reset to the inhibiting level
    logic oe_hi_d, oe_hi_q;
    wg_out_t out;

    always_comb begin
        oe_hi_d = oe_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_hi_q <= 1'b0;
        end else begin
            oe_hi_q <= oe_hi_d;
        end
    end

    always_comb begin
        out.inh = !ready || !oe_hi_q || (|stb_idle);
        out.wr  = ready && oe_hi_q && (&stb_low);
    end

    assign wr_qual_o    = out.wr;
    assign wr_inhibit_o = out.inh;

    // R1: bad supply blocks the write at the sampling edge
    p_supply_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> (!wr_qual_o && wr_inhibit_o));

    // R4: output enable low blocks the write
    p_oe_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_i |=> (!wr_qual_o && wr_inhibit_o));

    // R5: chip enable high blocks the write
    p_ce_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n_i |=> (!wr_qual_o && wr_inhibit_o));

    // R6: write enable high blocks the write
    p_we_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we_n_i |=> (!wr_qual_o && wr_inhibit_o));

    // R9: a qualified write never coexists with the inhibit flag
    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_qual_o && wr_inhibit_o));

    // R10: outputs idle right out of reset
    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (!wr_qual_o && wr_inhibit_o));

endmodule

// File: tb/sim_wg_write_guard.sv
module sim_wg_write_guard;
    localparam int unsigned HOLD = 20;
    localparam int unsigned GL   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic we_n = 1'b1;
    logic ce_n = 1'b1;
    logic oe_n = 1'b1;
    logic wr_qual, wr_inhibit;

    always #2.5 clk = ~clk;

    wg_write_guard #(
        .HOLD_CYCLES   (HOLD),
        .GLITCH_CYCLES (GL)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok_i  (supply_ok),
        .we_n_i       (we_n),
        .ce_n_i       (ce_n),
        .oe_n_i       (oe_n),
        .wr_qual_o    (wr_qual),
        .wr_inhibit_o (wr_inhibit)
    );

    typedef struct {
        bit    wr;
        bit    inh;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    // Requirement model: consecutive-sample counters
    int sup_run = 0;
    int we_run  = 0;
    int ce_run  = 0;

    task automatic step(input bit s, input bit we, input bit ce, input bit oe, input string tag);
        exp_t e;
        bit   ready, wl, cl;
        @(negedge clk);
        supply_ok = s; we_n = we; ce_n = ce; oe_n = oe;
        sup_run = s  ? sup_run + 1 : 0;
        we_run  = !we ? we_run + 1 : 0;
        ce_run  = !ce ? ce_run + 1 : 0;
        ready = (sup_run >= HOLD);
        wl    = (we_run >= GL);
        cl    = (ce_run >= GL);
        e.wr  = ready && oe && wl && cl;
        e.inh = !ready || !oe || we || ce;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic check_now(input bit wr_e, input bit inh_e, input string tag);
        n_cmp++;
        if (wr_qual !== wr_e || wr_inhibit !== inh_e) begin
            n_fail++;
            $display("FAIL %s: wr=%b inh=%b expected wr=%b inh=%b", tag, wr_qual, wr_inhibit, wr_e, inh_e);
        end
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check_now(e.wr, e.inh, e.tag);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_now(1'b0, 1'b1, "R10 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_now(1'b0, 1'b1, "R10 after reset");

        // R1: supply low with strobes active
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0, 1'b1, "R1");

        // R2: hold-off counting with strobes active
        for (int i = 0; i < HOLD + 3; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R2");

        // R1: supply drop while writing
        step(1'b0, 1'b0, 1'b0, 1'b1, "R1");

        // R3: partial hold-off, one bad sample, then full hold-off again
        for (int i = 0; i < HOLD - 2; i++) step(1'b1, 1'b1, 1'b1, 1'b1, "R3");
        step(1'b0, 1'b1, 1'b1, 1'b1, "R3");
        for (int i = 0; i < HOLD + 1; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R3");

        // R7: short pulses on both strobes, then on one only
        for (int k = 1; k < GL; k++) begin
            for (int i = 0; i < k; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R7");
            step(1'b1, 1'b1, 1'b1, 1'b1, "R7");
        end
        for (int i = 0; i < GL + 2; i++) step(1'b1, 1'b0, (i == 1), 1'b1, "R7");
        step(1'b1, 1'b1, 1'b1, 1'b1, "R7");

        // R8: long pulse, release through write enable, and through chip enable
        for (int i = 0; i < GL + 3; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R8");
        step(1'b1, 1'b1, 1'b0, 1'b1, "R8");
        for (int i = 0; i < GL + 1; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R8");
        step(1'b1, 1'b0, 1'b1, 1'b1, "R8");

        // R4: output enable low during a valid strobe
        for (int i = 0; i < GL + 2; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R4");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R4");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R4");

        // R5: chip enable high with write enable low
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 1'b1, "R5");

        // R6: write enable high with chip enable low
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b1, "R6");

        // R9: filter window in progress keeps the flag clear
        step(1'b1, 1'b1, 1'b1, 1'b1, "R9");
        for (int i = 0; i < GL + 1; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R9");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R9");

        step(1'b1, 1'b1, 1'b1, 1'b1, "R9");
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule